// File: doc/BRIEF.md
# SPI Register Slave with Trickle-Charge Control

This block is a serial slave that sits behind a four-wire SPI port: active-low select, serial clock, data in, and a tri-stated data out with its own enable. It gives a host access to a 128-byte register file. The slave works out the clock polarity from the idle level of the serial clock when select falls, so hosts in either polarity work without any setup. It samples all SPI pins with its own system clock, through synchronisers. The serial clock must therefore run well below the system clock. With the default two-stage synchroniser, each SCLK level must last at least four system clocks.

Each transfer starts with one address byte, sent MSB first. Address bit 7 set makes the transfer a write; bit 7 clear makes it a read. The low seven bits give the starting location. Each data byte that follows moves to the next location, and the address wraps from 7Fh to 00h. One location holds the trickle-charge configuration. This block turns its fields into a charger enable, a one-hot diode-path choice and a one-hot series-resistor choice.

A controller with four states runs the port:
- **ST_IDLE**: select is high and nothing happens. A falling select captures the polarity and moves to ST_ADDR.
- **ST_ADDR**: the address byte is shifted in. On its eighth bit the controller moves to ST_WDATA if bit 7 is set, and to ST_RDATA if it is clear.
- **ST_WDATA**: data bytes are shifted in. Each complete byte is stored.
- **ST_RDATA**: bytes are shifted out. This is the only state in which the output driver turns on.

A rising select returns any state to ST_IDLE.

Top module: `spi_chg_slave`

## Requirements
- R1: While cs_n is high, sclk and sdi have no effect on any register, and sdo_oe is low from the third system clock after cs_n rises.
- R2: The level of sclk at the falling edge of cs_n sets the polarity for the whole transfer. sdi is latched on the sclk edge that returns to that idle level. sdo changes on the edge that leaves it. Both idle-low and idle-high hosts are supported.
- R3: The first byte after cs_n falls is the address, sent MSB first. Bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6:0 give the start location.
- R4: sdo_oe stays low during the address byte and during writes. In a read, sdo_oe rises on the first leading edge after the address byte, and each stored byte is driven MSB first.
- R5: After each complete data byte, the location advances by one within seven bits. Location 7Fh is followed by 00h, for both reads and writes.
- R6: If cs_n rises before the eighth bit of a data byte, the partial byte is discarded and no register changes.
- R7: Reset clears every location to 00h and drives chg_en, diode_sel, res_sel and sdo_oe low.
- R8: The charge configuration lives at location 0Fh, so it is written with address byte 8Fh and read with 0Fh. Its fields are: key in bits 7:4, diode code in bits 3:2, resistor code in bits 1:0.
- R9: chg_en is high only when the key is 1010b and both the diode code and the resistor code are valid. Every other key gives chg_en low.
- R10: diode_sel is 01 for diode code 01 and 10 for diode code 10. Codes 00 and 11 give 00. The key does not affect diode_sel.
- R11: res_sel is 001 for code 01 (250 ohm), 010 for code 10 (2 kohm) and 100 for code 11 (4 kohm). Code 00 gives 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, either idle polarity |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host; high impedance when sdo_oe is low |
| sdo_oe | output | 1 | Output-driver enable for sdo |
| chg_en | output | 1 | Trickle-charger enable |
| diode_sel | output | 2 | One-hot diode path choice |
| res_sel | output | 3 | One-hot series resistor choice |

## Verification
The assertions check the following on every cycle: the output driver is off while select has been high, during the address byte, and in every state except ST_RDATA. The diode and resistor choices are never more than one-hot. The enable never rises without the 1010b key. The charge register changes only on a completed byte in ST_WDATA. Other behaviour can only be shown by the bench's transfers: correct sampling in each polarity, MSB-first order, location wrap at 7Fh, readback of stored values, and the discarding of a cut-short byte.

// File: rtl/spi_chg_pkg.sv
package spi_chg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } spi_state_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);
endpackage

// File: rtl/spi_front.sv
// Synchronises the SPI pins into the system clock domain, captures the
// idle polarity at select fall and classifies sclk edges.
module spi_front #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_s,
    output logic cs_fall,
    output logic lead,
    output logic trail,
    output logic sdi_s
);
    localparam logic [2:0] PIN_RST = 3'b001; // {sdi, sclk, cs_n}

    logic [SYNC_STAGES-1:0][2:0] chain;
    logic sclk_s, sclk_p, cs_p, cpol_q, sclk_moved;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain  <= {SYNC_STAGES{PIN_RST}};
            sclk_p <= 1'b0;
            cs_p   <= 1'b1;
            cpol_q <= 1'b0;
        end else begin
            chain  <= {chain[SYNC_STAGES-2:0], {sdi, sclk, cs_n}};
            sclk_p <= sclk_s;
            cs_p   <= cs_s;
            if (cs_fall) cpol_q <= sclk_s;
        end
    end

    assign cs_s       = chain[SYNC_STAGES-1][0];
    assign sclk_s     = chain[SYNC_STAGES-1][1];
    assign sdi_s      = chain[SYNC_STAGES-1][2];
    assign cs_fall    = cs_p && !cs_s;
    assign sclk_moved = (sclk_s != sclk_p) && !cs_s && !cs_fall;
    assign lead       = sclk_moved && (sclk_s != cpol_q);
    assign trail      = sclk_moved && (sclk_s == cpol_q);
endmodule

// File: rtl/spi_reg_file.sv
// Byte-wide register file with one write port, one read port and a
// dedicated tap on the charge configuration location.
module spi_reg_file #(
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned DATA_W   = 8,
    parameter logic [ADDR_W-1:0] TAP_ADDR = 7'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] tap_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_loc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                mem[g] <= wr_data;
        end
    end

    assign rd_data  = mem[rd_addr];
    assign tap_data = mem[TAP_ADDR];
endmodule

// File: rtl/chg_decode.sv
// Turns the charge configuration byte into enable and one-hot selects.
module chg_decode #(
    parameter logic [3:0] KEY = 4'b1010
) (
    input  logic [7:0] cfg,
    output logic       chg_en,
    output logic [1:0] diode_sel,
    output logic [2:0] res_sel
);
    always_comb begin
        unique case (cfg[3:2])
            2'b01:   diode_sel = 2'b01;
            2'b10:   diode_sel = 2'b10;
            default: diode_sel = 2'b00;
        endcase
        unique case (cfg[1:0])
            2'b01:   res_sel = 3'b001;
            2'b10:   res_sel = 3'b010;
            2'b11:   res_sel = 3'b100;
            default: res_sel = 3'b000;
        endcase
        chg_en = (cfg[7:4] == KEY) && (diode_sel != 2'b00) && (res_sel != 3'b000);
    end
endmodule

// File: rtl/spi_chg_slave.sv
module spi_chg_slave
    import spi_chg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CHG_ADDR = 7'h0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdi,
    output logic       sdo,
    output logic       sdo_oe,
    output logic       chg_en,
    output logic [1:0] diode_sel,
    output logic [2:0] res_sel
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    spi_state_e state_q, state_d;
    logic cs_s, cs_fall, lead, trail, sdi_s;
    logic [CNT_W-1:0]  bit_cnt, rd_cnt;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] rx_sh, rx_next, tx_sh, rd_data, chg_reg;
    logic sdo_bit, oe_q, wr_en;

    spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .cs_s(cs_s), .cs_fall(cs_fall), .lead(lead), .trail(trail), .sdi_s(sdi_s)
    );

    assign rx_next = {rx_sh[BYTE_W-2:0], sdi_s};
    assign wr_en   = (state_q == ST_WDATA) && trail && (bit_cnt == LAST_BIT);

    spi_reg_file #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W), .TAP_ADDR(CHG_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(rx_next),
        .rd_addr(ptr), .rd_data(rd_data), .tap_data(chg_reg)
    );

    chg_decode u_dec (
        .cfg(chg_reg), .chg_en(chg_en), .diode_sel(diode_sel), .res_sel(res_sel)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall) state_d = ST_ADDR;
            ST_ADDR: begin
                if (cs_s)
                    state_d = ST_IDLE;
                else if (trail && (bit_cnt == LAST_BIT))
                    state_d = rx_next[BYTE_W-1] ? ST_WDATA : ST_RDATA;
            end
            ST_WDATA: if (cs_s) state_d = ST_IDLE;
            ST_RDATA: if (cs_s) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift, count and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rd_cnt  <= '0;
            ptr     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            sdo_bit <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    rd_cnt  <= '0;
                    oe_q    <= 1'b0;
                end
                ST_ADDR, ST_WDATA: begin
                    if (trail) begin
                        rx_sh   <= rx_next;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT)
                            ptr <= (state_q == ST_ADDR) ? rx_next[ADDR_W-1:0] : ptr + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (cs_s) begin
                        oe_q <= 1'b0;
                    end else if (lead) begin
                        oe_q <= 1'b1;
                        if (rd_cnt == '0) begin
                            sdo_bit <= rd_data[BYTE_W-1];
                            tx_sh   <= {rd_data[BYTE_W-2:0], 1'b0};
                        end else begin
                            sdo_bit <= tx_sh[BYTE_W-1];
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                        end
                        rd_cnt <= rd_cnt + 1'b1;
                        if (rd_cnt == LAST_BIT) ptr <= ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sdo_oe = oe_q;
    assign sdo    = oe_q ? sdo_bit : 1'bz;
endmodule

// File: rtl/spi_chg_slave_checker.sv
module spi_chg_slave_checker
    import spi_chg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdo_oe,
    input logic       chg_en,
    input logic [1:0] diode_sel,
    input logic [2:0] res_sel,
    input spi_state_e state,
    input logic [7:0] chg_reg
);
    assert_cs_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

    assert_addr_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |-> !sdo_oe);

    assert_oe_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (state == ST_RDATA));

    assert_whole_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chg_reg) |-> ($past(state) == ST_WDATA));

    assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!chg_en && !sdo_oe));

    assert_key_needed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_en |-> (chg_reg[7:4] == 4'b1010));

    assert_diode_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(diode_sel));

    assert_res_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_sel));
endmodule

bind spi_chg_slave spi_chg_slave_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe), .chg_en(chg_en),
    .diode_sel(diode_sel), .res_sel(res_sel), .state(state_q), .chg_reg(chg_reg)
);

// File: tb/spi_chg_slave_test.sv
`timescale 1ns/1ps
module spi_chg_slave_test;
    localparam int HALF = 8;
    localparam logic [6:0] CFG = 7'h0F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, chg_en;
    logic [1:0] diode_sel;
    logic [2:0] res_sel;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    bit cpol_b = 1'b0;
    logic [7:0] model [128];
    logic [7:0] wbuf [8];

    always #2 clk = ~clk;

    spi_chg_slave uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .chg_en(chg_en),
        .diode_sel(diode_sel), .res_sel(res_sel)
    );

    function automatic logic [1:0] exp_diode(input logic [7:0] v);
        case (v[3:2])
            2'b01:   return 2'b01;
            2'b10:   return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [2:0] exp_res(input logic [7:0] v);
        case (v[1:0])
            2'b01:   return 3'b001;
            2'b10:   return 3'b010;
            2'b11:   return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic exp_en(input logic [7:0] v);
        return (v[7:4] == 4'b1010) && (exp_diode(v) != 0) && (exp_res(v) != 0);
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag);
        repeat (4) @(negedge clk);
        chk(chg_en === exp_en(model[CFG]), {tag, " R9 chg_en"}, 32'(chg_en), 32'(exp_en(model[CFG])));
        chk(diode_sel === exp_diode(model[CFG]), {tag, " R10 diode_sel"}, 32'(diode_sel), 32'(exp_diode(model[CFG])));
        chk(res_sel === exp_res(model[CFG]), {tag, " R11 res_sel"}, 32'(res_sel), 32'(exp_res(model[CFG])));
    endtask

    task automatic begin_xfer(input bit cp);
        cpol_b = cp;
        sclk = cp;
        repeat (6) @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic end_xfer();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Leading edge drives sdi, trailing edge returns to idle (data latch).
    task automatic shift_bits(input logic [7:0] tx, input int nbits, input bit exp_oe,
                              output logic [7:0] rx);
        int oe_bad = 0;
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sclk = ~cpol_b;
            sdi = tx[i];
            repeat (HALF) @(negedge clk);
            if (sdo_oe !== exp_oe) oe_bad++;
            rx[i] = sdo;
            sclk = cpol_b;
            repeat (HALF) @(negedge clk);
        end
        chk(oe_bad == 0, exp_oe ? "R4 sdo_oe high in read byte" : "R4 sdo_oe low outside read",
            32'(oe_bad), 0);
    endtask

    task automatic do_write(input bit cp, input logic [6:0] a, input int n, input string tag);
        logic [7:0] rx;
        begin_xfer(cp);
        shift_bits({1'b1, a}, 8, 1'b0, rx);
        for (int k = 0; k < n; k++) begin
            shift_bits(wbuf[k], 8, 1'b0, rx);
            model[7'(a + 7'(k))] = wbuf[k];
        end
        end_xfer();
        chk_outs(tag);
    endtask

    task automatic do_read(input bit cp, input logic [6:0] a, input int n, input string tag);
        logic [7:0] rx;
        logic [6:0] loc;
        begin_xfer(cp);
        shift_bits({1'b0, a}, 8, 1'b0, rx);
        for (int k = 0; k < n; k++) begin
            loc = 7'(a + 7'(k));
            shift_bits(8'h00, 8, 1'b1, rx);
            chk(rx === model[loc], {tag, " R3 R5 read data"}, 32'(rx), 32'(model[loc]));
        end
        end_xfer();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        logic [6:0] a;
        int n;
        void'($urandom(32'h5eed));
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7: reset state
        chk(sdo_oe === 1'b0, "R7 sdo_oe after reset", 32'(sdo_oe), 0);
        chk_outs("R7 reset");
        do_read(1'b0, CFG, 2, "R7 reset contents");

        // R8 R2: write configuration in idle-low mode, read back in idle-high mode
        wbuf[0] = 8'hA5;
        do_write(1'b0, CFG, 1, "R8 R2 cpol0 A5");
        do_read(1'b1, CFG, 1, "R2 cpol1 readback");

        // R9 R10 R11: decode corners
        begin
            logic [7:0] pats [7] = '{8'hA9, 8'hAB, 8'hA6, 8'hA8, 8'hAD, 8'h5A, 8'hB5};
            for (int p = 0; p < 7; p++) begin
                wbuf[0] = pats[p];
                do_write(p[0], CFG, 1, "R9 R10 R11 decode");
            end
        end
        wbuf[0] = 8'hAA;
        do_write(1'b1, CFG, 1, "R9 key AA");

        // R6: cut-short data byte leaves register untouched
        begin_xfer(1'b0);
        shift_bits({1'b1, CFG}, 8, 1'b0, rx);
        shift_bits(8'h00, 4, 1'b0, rx);
        end_xfer();
        chk_outs("R6 partial byte");
        do_read(1'b1, CFG, 1, "R6 readback");

        // R1: activity while deselected is ignored
        begin
            int oe_bad = 0;
            cs_n = 1'b1;
            for (int i = 0; i < 40; i++) begin
                sclk = ~sclk;
                sdi = 1'($urandom);
                repeat (3) @(negedge clk);
                if (sdo_oe !== 1'b0) oe_bad++;
            end
            chk(oe_bad == 0, "R1 sdo_oe while deselected", 32'(oe_bad), 0);
        end
        chk_outs("R1 deselected");
        do_read(1'b0, CFG, 1, "R1 readback");

        // R5: location wraps from 7Fh to 00h
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
        do_write(1'b1, 7'h7F, 2, "R5 wrap write");
        do_read(1'b0, 7'h7F, 2, "R5 wrap read");

        // R5: burst across the configuration location
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'hA6; wbuf[3] = 8'h44;
        do_write(1'b0, 7'h0D, 4, "R5 burst write");
        do_read(1'b1, 7'h0C, 5, "R5 burst read");

        // Constrained random mix
        for (int t = 0; t < 60; t++) begin
            a = 7'h0B + 7'($urandom_range(0, 8));
            if ($urandom_range(0, 9) == 0) a = 7'h7E;
            n = $urandom_range(1, 4);
            if ($urandom_range(0, 1) == 1) begin
                for (int k = 0; k < n; k++) begin
                    wbuf[k] = 8'($urandom);
                    if ($urandom_range(0, 1) == 1) wbuf[k][7:4] = 4'b1010;
                end
                do_write(1'($urandom), a, n, "R2 R3 R9 random write");
            end else begin
                do_read(1'($urandom), a, n, "R2 R4 random read");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule